// File: doc/BRIEF.md
# Checkpointed Register File with Gated Store Buffer

This block holds the architectural registers of a speculative execution engine in two copies. The working copy takes every register write as speculative code runs. The shadow copy keeps the state as it stood at the last checkpoint. Stores issued during speculation do not go to memory. They wait in a small ordered buffer, and loads look in that buffer before they take data from memory.

At the end of a translated code block a single `commit` pulse does two things. It copies every working register into its shadow copy, and it releases the buffered stores. Those stores then drain to memory in program order, one per cycle, through a valid/ready write port. When an exception occurs, a `rollback` pulse reloads every working register from its shadow copy and throws away all stores that have not been released. Execution can then restart from a precise checkpoint.

A register write can cover the whole word or only its low byte. A low-byte write leaves the upper bits unchanged.

Top module: `ckpt_core`

## Requirements
- R1: After a synchronous reset, every working and every shadow register reads zero, the buffer is empty, `mem_wvalid` is low, and `ld_data` equals `ld_mem_data`.
- R2: When `wr_en` is high at a clock edge, the working copy of register `wr_idx` is updated. The shadow copy changes only on a commit.
- R3: When `wr_lo_only` is 1, a write replaces bits 7:0 of the working register and leaves bits 31:8 unchanged. When `wr_lo_only` is 0, the write replaces all 32 bits.
- R4: On `commit` without `rollback`, every shadow register takes its working value. A write in the same cycle is included in the committed value.
- R5: On `rollback`, every working register is reloaded from its shadow copy. A write or a commit in the same cycle has no effect.
- R6: Buffered stores never reach memory before a commit. `mem_wvalid` rises only in the cycle after a commit that finds the buffer non-empty, counting a store accepted in that same cycle.
- R7: `ld_data` is formed byte by byte. Byte lane i (bits 8i+7:8i) comes from the most recently accepted buffered store to `ld_addr` whose `st_be[i]` is 1. If no such store exists, it comes from `ld_mem_data`.
- R8: After a commit, stores drain in acceptance order, one per cycle in which `mem_wready` is high. The address, data and byte enables are held while `mem_wready` is low. New stores are refused with `st_stall` while the drain runs.
- R9: The buffer holds 8 stores. A store presented while the buffer is full raises `st_stall` and is not accepted. It is accepted once the producer holds it until `st_stall` falls.
- R10: A rollback outside a drain discards every buffered store, and no memory write follows. A rollback during a drain leaves the released stores draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register written |
| wr_data | input | 32 | Write data |
| wr_lo_only | input | 1 | 1: update bits 7:0 only |
| rd_idx | input | 3 | Register read |
| rd_work | output | 32 | Working copy of `rd_idx` |
| rd_shadow | output | 32 | Shadow copy of `rd_idx` |
| st_valid | input | 1 | Speculative store request |
| st_addr | input | 16 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables, bit i covers bits 8i+7:8i |
| st_stall | output | 1 | Store not accepted this cycle (buffer full or draining) |
| ld_addr | input | 16 | Load word address |
| ld_mem_data | input | 32 | Memory data at `ld_addr` |
| ld_data | output | 32 | Load result after buffer forwarding |
| commit | input | 1 | Checkpoint pulse |
| rollback | input | 1 | Exception restore pulse |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory accepts the write |
| mem_waddr | output | 16 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_wbe | output | 4 | Memory write byte enables |

## Verification
The bench builds the block with its default parameters: eight registers and an eight-entry buffer. It limits store and load addresses to eight words, so most loads hit several buffered stores with mixed byte enables, and youngest-wins merging is exercised constantly. Because the buffer is only eight deep, random runs fill it often. Directed sequences add a full buffer, a commit or rollback landing on a register write, and a rollback in the middle of a drain.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int NB = DW / 8;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NB-1:0] be;
    } st_entry_t;

    function automatic logic [DW-1:0] lo_byte_merge(input logic [DW-1:0] old_v,
                                                    input logic [DW-1:0] new_v,
                                                    input logic          lo_only);
        return lo_only ? {old_v[DW-1:8], new_v[7:0]} : new_v;
    endfunction
endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile import ckpt_pkg::*; #(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_lo_only,
    input  logic          commit,
    input  logic          rollback,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_work,
    output logic [DW-1:0] rd_shadow
);
    logic [DW-1:0] work_q [NREG];
    logic [DW-1:0] shad_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] nxt;
        always_comb begin
            nxt = work_q[g];
            if (wr_en && wr_idx == IW'(g))
                nxt = lo_byte_merge(work_q[g], wr_data, wr_lo_only);
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                work_q[g] <= '0;
                shad_q[g] <= '0;
            end else if (rollback) begin
                work_q[g] <= shad_q[g];
            end else begin
                work_q[g] <= nxt;
                if (commit) shad_q[g] <= nxt;
            end
        end
    end

    assign rd_work   = work_q[rd_idx];
    assign rd_shadow = shad_q[rd_idx];
endmodule

// File: rtl/ckpt_storebuf.sv
module ckpt_storebuf import ckpt_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      st_valid,
    input  st_entry_t st_entry,
    output logic      st_stall,
    input  logic      commit,
    input  logic      rollback,
    output logic      mem_wvalid,
    input  logic      mem_wready,
    output st_entry_t mem_entry,
    output st_entry_t ent_q [DEPTH],
    output logic [CW-1:0] cnt_q
);
    logic drain_q;
    logic full, push, pop;

    assign full       = (cnt_q == CW'(DEPTH));
    assign push       = st_valid && !full && !drain_q && !rollback;
    assign st_stall   = st_valid && (full || drain_q);
    assign mem_wvalid = drain_q && (cnt_q != '0);
    assign mem_entry  = ent_q[0];
    assign pop        = mem_wvalid && mem_wready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            drain_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (drain_q) begin
            if (pop) begin
                for (int i = 0; i < DEPTH - 1; i++) ent_q[i] <= ent_q[i+1];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) drain_q <= 1'b0;
            end
        end else if (rollback) begin
            cnt_q <= '0;
        end else begin
            if (push) begin
                for (int i = 0; i < DEPTH; i++)
                    if (cnt_q == CW'(i)) ent_q[i] <= st_entry;
                cnt_q <= cnt_q + 1'b1;
            end
            if (commit && (cnt_q != '0 || push)) drain_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ckpt_snoop.sv
module ckpt_snoop import ckpt_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  st_entry_t     ent [DEPTH],
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    output logic [DW-1:0] ld_data
);
    always_comb begin
        ld_data = ld_mem_data;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt && ent[i].addr == ld_addr) begin
                for (int b = 0; b < NB; b++)
                    if (ent[i].be[b]) ld_data[8*b +: 8] = ent[i].data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/ckpt_core.sv
module ckpt_core import ckpt_pkg::*; #(
    parameter int NREG     = 8,
    parameter int SB_DEPTH = 8,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(SB_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_lo_only,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_work,
    output logic [DW-1:0] rd_shadow,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [NB-1:0] st_be,
    output logic          st_stall,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    output logic [DW-1:0] ld_data,
    input  logic          commit,
    input  logic          rollback,
    output logic          mem_wvalid,
    input  logic          mem_wready,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [NB-1:0] mem_wbe
);
    st_entry_t     st_in, head;
    st_entry_t     ents [SB_DEPTH];
    logic [CW-1:0] cnt;

    assign st_in = '{addr: st_addr, data: st_data, be: st_be};

    ckpt_regfile #(.NREG(NREG)) u_rf (
        .clk, .rst, .wr_en, .wr_idx, .wr_data, .wr_lo_only,
        .commit, .rollback, .rd_idx, .rd_work, .rd_shadow
    );

    ckpt_storebuf #(.DEPTH(SB_DEPTH)) u_sb (
        .clk, .rst, .st_valid, .st_entry(st_in), .st_stall,
        .commit, .rollback, .mem_wvalid, .mem_wready,
        .mem_entry(head), .ent_q(ents), .cnt_q(cnt)
    );

    ckpt_snoop #(.DEPTH(SB_DEPTH)) u_sn (
        .ent(ents), .cnt, .ld_addr, .ld_mem_data, .ld_data
    );

    assign mem_waddr = head.addr;
    assign mem_wdata = head.data;
    assign mem_wbe   = head.be;
endmodule

// File: rtl/ckpt_core_chk.sv
module ckpt_core_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          commit,
    input logic          rollback,
    input logic          st_valid,
    input logic          st_stall,
    input logic          mem_wvalid,
    input logic          mem_wready,
    input logic [15:0]   mem_waddr,
    input logic [31:0]   mem_wdata,
    input logic [3:0]    mem_wbe,
    input logic [IW-1:0] rd_idx,
    input logic [31:0]   rd_work,
    input logic [31:0]   rd_shadow
);
    p_shadow_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> (!$stable(rd_idx) || $stable(rd_shadow)));

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !rollback) |=> (rd_shadow == rd_work));

    p_rollback_restore_r5: assert property (@(posedge clk) disable iff (rst)
        rollback |=> (rd_work == rd_shadow));

    p_no_early_write_r6: assert property (@(posedge clk) disable iff (rst)
        (!mem_wvalid && !commit) |=> !mem_wvalid);

    p_hold_write_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready) |=>
            (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata) && $stable(mem_wbe)));

    p_stall_in_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && st_valid) |-> st_stall);
endmodule

bind ckpt_core ckpt_core_chk #(.IW(IW)) u_chk (.*);

// File: tb/sim_ckpt_core.sv
module sim_ckpt_core;
    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic        wr_en = 0, wr_lo_only = 0, st_valid = 0, commit = 0, rollback = 0, mem_wready = 0;
    logic [2:0]  wr_idx = 0, rd_idx = 0;
    logic [31:0] wr_data = 0, st_data = 0, ld_mem_data, rd_work, rd_shadow, ld_data, mem_wdata;
    logic [15:0] st_addr = 0, ld_addr = 0, mem_waddr;
    logic [3:0]  st_be = 0, mem_wbe;
    logic        st_stall, mem_wvalid;

    ckpt_core u0 (.*);

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] mw [8];
    logic [31:0] ms [8];
    logic [31:0] memm [8];
    logic [15:0] qa [8];
    logic [31:0] qd [8];
    logic [3:0]  qb [8];
    int qn = 0;
    bit qdrain = 0;

    assign ld_mem_data = memm[ld_addr[2:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_load(input logic [15:0] a);
        logic [31:0] r = memm[a[2:0]];
        for (int i = 0; i < qn; i++) if (qa[i] == a) r = bmerge(r, qd[i], qb[i]);
        return r;
    endfunction

    // Called just after a negedge with inputs already driven.
    task automatic tick();
        bit pop;
        #1;
        chk("R2 working copy", rd_work, mw[rd_idx]);
        chk("R4 shadow copy", rd_shadow, ms[rd_idx]);
        chk("R9/R8 stall", {31'd0, st_stall}, {31'd0, st_valid && (qn == 8 || qdrain)});
        chk("R6 write valid", {31'd0, mem_wvalid}, {31'd0, qdrain && qn > 0});
        if (mem_wvalid && qn > 0) begin
            chk("R8 drain addr", {16'd0, mem_waddr}, {16'd0, qa[0]});
            chk("R8 drain data", mem_wdata, qd[0]);
            chk("R8 drain be", {28'd0, mem_wbe}, {28'd0, qb[0]});
        end
        chk("R7 load forward", ld_data, exp_load(ld_addr));
        @(posedge clk);
        pop = qdrain && qn > 0 && mem_wready;
        if (qdrain) begin
            if (pop) begin
                memm[qa[0][2:0]] = bmerge(memm[qa[0][2:0]], qd[0], qb[0]);
                for (int i = 0; i < 7; i++) begin qa[i] = qa[i+1]; qd[i] = qd[i+1]; qb[i] = qb[i+1]; end
                qn--;
                if (qn == 0) qdrain = 0;
            end
        end else if (rollback) begin
            qn = 0;
        end else begin
            if (st_valid && qn < 8) begin
                qa[qn] = st_addr; qd[qn] = st_data; qb[qn] = st_be; qn++;
            end
            if (commit && qn > 0) qdrain = 1;
        end
        if (rollback) begin
            for (int i = 0; i < 8; i++) mw[i] = ms[i];
        end else begin
            if (wr_en) mw[wr_idx] = wr_lo_only ? {mw[wr_idx][31:8], wr_data[7:0]} : wr_data;
            if (commit) for (int i = 0; i < 8; i++) ms[i] = mw[i];
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; st_valid = 0; commit = 0; rollback = 0;
    endtask

    task automatic store(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        idle(); st_valid = 1; st_addr = a; st_data = d; st_be = be; tick();
    endtask

    task automatic wreg(input logic [2:0] i, input logic [31:0] d, input logic lo);
        idle(); wr_en = 1; wr_idx = i; wr_data = d; wr_lo_only = lo; rd_idx = i; tick();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin mw[i] = 0; ms[i] = 0; memm[i] = 32'h1000_0000 * i + 32'h0101_0101; end
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i); ld_addr = 16'(i); #1;
            chk("R1 reset work", rd_work, 32'd0);
            chk("R1 reset shadow", rd_shadow, 32'd0);
            chk("R1 reset load", ld_data, memm[i]);
        end
        chk("R1 reset wvalid", {31'd0, mem_wvalid}, 32'd0);
        @(negedge clk);

        // R3 low-byte write, R2 shadow untouched
        wreg(3'd2, 32'hAABBCCDD, 1'b0);
        wreg(3'd2, 32'h11223344, 1'b1);
        idle(); rd_idx = 3'd2; #1;
        chk("R3 low byte only", rd_work, 32'hAABBCC44);
        chk("R2 shadow unchanged", rd_shadow, 32'd0);
        tick();

        // R4 commit with same-cycle write
        idle(); wr_en = 1; wr_idx = 3'd5; wr_data = 32'hCAFE0005; wr_lo_only = 0; commit = 1; tick();
        idle(); rd_idx = 3'd5; #1;
        chk("R4 commit includes write", rd_shadow, 32'hCAFE0005);
        tick();

        // R5 rollback beats write and commit
        wreg(3'd5, 32'h0BAD0BAD, 1'b0);
        idle(); wr_en = 1; wr_idx = 3'd5; wr_data = 32'h12345678; commit = 1; rollback = 1; tick();
        idle(); rd_idx = 3'd5; #1;
        chk("R5 rollback restores", rd_work, 32'hCAFE0005);
        chk("R5 rollback blocks commit", rd_shadow, 32'hCAFE0005);
        tick();

        // R9 fill buffer, 9th store stalls; R7 youngest wins
        for (int i = 0; i < 8; i++) store(16'd3, 32'h0 + 32'h0101_0101 * (i + 1), (i == 7) ? 4'b0001 : 4'b1111);
        idle(); st_valid = 1; st_addr = 16'd4; st_data = 32'hDEADBEEF; st_be = 4'hF; ld_addr = 16'd3; #1;
        chk("R9 full stall", {31'd0, st_stall}, 32'd1);
        chk("R7 youngest per byte", ld_data, 32'h07070708);
        tick();
        // R10 rollback drops all
        idle(); rollback = 1; tick();
        idle(); ld_addr = 16'd3; #1;
        chk("R10 dropped stores", ld_data, memm[3]);
        chk("R10 no write", {31'd0, mem_wvalid}, 32'd0);
        tick();

        // R6/R8 commit and drain, rollback mid-drain keeps draining
        store(16'd1, 32'hA1A1A1A1, 4'b0011);
        store(16'd2, 32'hB2B2B2B2, 4'b1111);
        store(16'd1, 32'hC3C3C3C3, 4'b1100);
        idle(); commit = 1; tick();
        idle(); mem_wready = 0; tick(); tick();
        mem_wready = 1; tick();
        idle(); rollback = 1; mem_wready = 1; #1;
        chk("R10 drain survives rollback", {31'd0, mem_wvalid}, 32'd1);
        tick();
        idle(); repeat (3) tick();
        chk("R8 drained result", memm[1], 32'hC3C3A1A1);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            wr_en      = ($urandom % 2) == 0;
            wr_idx     = 3'($urandom);
            wr_data    = $urandom;
            wr_lo_only = ($urandom % 10) < 3;
            rd_idx     = 3'($urandom);
            st_valid   = ($urandom % 10) < 5;
            st_addr    = 16'($urandom % 8);
            st_data    = $urandom;
            st_be      = 4'($urandom);
            ld_addr    = 16'($urandom % 8);
            commit     = ($urandom % 100) < 7;
            rollback   = ($urandom % 100) < 4;
            mem_wready = ($urandom % 10) < 7;
            tick();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule